// File: doc/BRIEF.md
# Pulse-Per-Second Period Capture Receiver

This block takes a once-per-second reference pulse from an external timing source and measures, in cycles of the local interface clock, how far apart successive pulses arrive. A counter runs on the local clock. When a rising edge of the reference is detected, the counter value is copied into an output register and the counter restarts from zero. In the same cycle the block raises a one-cycle interrupt.

A sticky flag reports that the reference has gone missing. It sets once the counter has run up to a large threshold (2^28 cycles by default) without an edge arriving. Only a later reference edge clears it. The counter saturates instead of wrapping, so a dead reference cannot restart the measurement by itself. A build parameter removes the whole receiver. When it is off, no logic is built and every output is tied to zero. The parameter is off by default, so an integrating design has to turn it on explicitly.

Top module: `pps_stamp`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `stamp`, `tick_irq` and `ref_lost` are all zero.
- R2: `pps_in` passes through two synchronizing flops, and only a 0-to-1 transition of the synchronized level counts as a reference edge. The edge updates `stamp` and pulses `tick_irq` on the third rising clock edge that samples `pps_in` high.
- R3: When two reference edges are detected N clock cycles apart, `stamp` holds N-1 after the second edge, as long as N-1 does not exceed 2^CNT_W-1.
- R4: The counter stops at 2^CNT_W-1 instead of wrapping. An edge that follows a longer gap captures exactly 2^CNT_W-1.
- R5: `ref_lost` becomes 1 on the clock edge after the counter has reached 2^LOSS_LOG2. Consequently a gap of 2^LOSS_LOG2+1 cycles or less never raises it, and a gap of 2^LOSS_LOG2+2 cycles raises it one cycle before the edge.
- R6: Once set, `ref_lost` stays at 1 until a reference edge arrives. It falls in the same cycle as that edge's `tick_irq`.
- R7: `pps_in` held high for many cycles produces exactly one `tick_irq`.
- R8: `tick_irq` is never high on two consecutive cycles, and `stamp` changes only in a cycle in which `tick_irq` is high.
- R9: With ENABLE = 0, all outputs are constant zero whatever `pps_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local interface clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous reference pulse |
| stamp | output | CNT_W | Cycle count captured at the latest reference edge |
| tick_irq | output | 1 | One-cycle interrupt per reference edge |
| ref_lost | output | 1 | Sticky missing-reference flag |

## Verification
Several rules are checked by the assertions on every cycle:
- the interrupt lasts one cycle;
- `stamp` moves only together with the interrupt;
- the loss flag falls only on an edge and is never high together with the interrupt;
- a saturated counter stays saturated.

The measured values themselves can only be shown by the bench's pulse trains, because they depend on the history of gaps. These are the N-1 capture, the saturated capture, the exact threshold where the loss flag appears, the single interrupt for a long-held input, and the silent disabled build.

// File: rtl/pps_stamp.sv
module pps_stamp #(
  parameter bit ENABLE    = 1'b0,
  parameter int CNT_W     = 32,
  parameter int LOSS_LOG2 = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_in,
  output logic [CNT_W-1:0] stamp,
  output logic             tick_irq,
  output logic             ref_lost
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LOSS_AT = {{(CNT_W-1){1'b0}}, 1'b1} << LOSS_LOG2;

  generate
    if (ENABLE) begin : g_on
      logic             sync_a, sync_b, sync_q;
      logic [CNT_W-1:0] cnt;
      logic             edge_hit;

      assign edge_hit = sync_b & ~sync_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          sync_a <= 1'b0;
          sync_b <= 1'b0;
          sync_q <= 1'b0;
        end else begin
          sync_a <= pps_in;
          sync_b <= sync_a;
          sync_q <= sync_b;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt      <= '0;
          stamp    <= '0;
          tick_irq <= 1'b0;
          ref_lost <= 1'b0;
        end else if (edge_hit) begin
          cnt      <= '0;
          stamp    <= cnt;
          tick_irq <= 1'b1;
          ref_lost <= 1'b0;
        end else begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          tick_irq <= 1'b0;
          if (cnt >= LOSS_AT) ref_lost <= 1'b1;
        end
      end

      assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
        tick_irq |=> !tick_irq);
      assert_stamp_moves_with_irq_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(stamp) |-> tick_irq);
      assert_lost_clears_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_lost) |-> tick_irq);
      assert_lost_low_at_irq_R6: assert property (@(posedge clk) disable iff (rst)
        tick_irq |-> !ref_lost);
      assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !edge_hit) |=> cnt == CNT_MAX);
    end else begin : g_off
      assign stamp    = '0;
      assign tick_irq = 1'b0;
      assign ref_lost = 1'b0;
    end
  endgenerate

endmodule

// File: tb/pps_stamp_test.sv
module pps_stamp_test;
  localparam int CNT_W = 8;
  localparam int LOSS_LOG2 = 6;
  localparam int THR = 1 << LOSS_LOG2;
  localparam int SAT = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pps_in = 1'b0;
  logic [CNT_W-1:0] stamp, stamp_off;
  logic tick_irq, ref_lost, irq_off, lost_off;

  always #2ns clk = ~clk;

  pps_stamp #(.ENABLE(1'b1), .CNT_W(CNT_W), .LOSS_LOG2(LOSS_LOG2)) uut (
    .clk(clk), .rst(rst), .pps_in(pps_in),
    .stamp(stamp), .tick_irq(tick_irq), .ref_lost(ref_lost));

  pps_stamp #(.ENABLE(1'b0), .CNT_W(CNT_W), .LOSS_LOG2(LOSS_LOG2)) uut_off (
    .clk(clk), .rst(rst), .pps_in(pps_in),
    .stamp(stamp_off), .tick_irq(irq_off), .ref_lost(lost_off));

  int tests = 0;
  int fails = 0;
  int exp_cap[$];
  bit exp_lost[$];
  int irq_seen = 0;
  int rises = 0;
  int last_gap = -1;
  bit prev_lost = 1'b0;
  bit prev_irq = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int width, input int gap);
    if (last_gap >= 0) begin
      exp_cap.push_back(last_gap - 1 > SAT ? SAT : last_gap - 1);
      exp_lost.push_back(last_gap >= THR + 2);
    end
    rises++;
    pps_in = 1'b1;
    repeat (width) @(negedge clk);
    pps_in = 1'b0;
    repeat (gap - width) @(negedge clk);
    last_gap = gap;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(!(irq_off || lost_off || stamp_off != 0), "R9", int'(stamp_off) + int'(irq_off) + int'(lost_off), 0);
      if (tick_irq) begin
        check(!prev_irq, "R8", 1, 0);
        check(!ref_lost, "R6", ref_lost, 0);
        if (irq_seen > 0) begin
          if (exp_cap.size() == 0) check(1'b0, "R7", irq_seen, rises);
          else begin
            int c;
            bit l;
            c = exp_cap.pop_front();
            l = exp_lost.pop_front();
            check(int'(stamp) == c, c == SAT ? "R4" : "R3", stamp, c);
            check(prev_lost == l, "R5", prev_lost, l);
          end
        end
        irq_seen++;
      end
      prev_lost = ref_lost;
      prev_irq = tick_irq;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(stamp == 0 && !tick_irq && !ref_lost, "R1", stamp, 0);
    rst = 1'b0;
    @(negedge clk);
    check(stamp == 0 && !tick_irq && !ref_lost, "R1", stamp, 0);
    pulse(3, 20);
    // R2: an edge driven just after a negedge shows at the third posedge
    pps_in = 1'b1;
    @(negedge clk); check(!tick_irq, "R2", tick_irq, 0);
    @(negedge clk); check(!tick_irq, "R2", tick_irq, 0);
    @(negedge clk); check(tick_irq == 1'b1, "R2", tick_irq, 1);
    check(stamp == 19, "R3", stamp, 19);
    irq_seen = 0;
    pps_in = 1'b0;
    repeat (17) @(negedge clk);
    pulse(3, 10);
    pulse(3, 7);
    pulse(3, THR + 1);
    pulse(3, THR + 2);
    pulse(3, 100);
    pulse(30, 40);   // R7: long-held input
    pulse(3, 300);   // R4: saturating gap
    pulse(3, 12);
    pulse(3, 20);
    check(exp_cap.size() == 0, "R3", exp_cap.size(), 0);
    check(irq_seen == rises, "R7", irq_seen, rises);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule